// File: doc/BRIEF.md
# Interconnect Performance Counter Block

This block counts activity inside a coherent interconnect so that software can measure traffic and stalls. It holds five 32-bit counters. Counter 0 counts clock cycles. Counters 1 to 4 each count one selectable event. The event sources arrive as a flat vector of single-cycle pulses, indexed by an 8-bit selector. The selector is made of a 3-bit source-port number and a 5-bit event code.

Software reaches the block through a register port with one-cycle writes and combinational reads. Each counter has its own 4 KB page holding four registers: its event select, its count, its enable and a sticky overflow flag. A global control word in the cycle counter's page holds one master enable for all counters. The same word also reports how many event counters the block has. Each counter drives its own interrupt line, which stays high while that counter's overflow flag is set.

Top module: `icpmu_top`

## Requirements
- R1: After reset, every count is 0, every enable and overflow flag is 0, every interrupt output is low, and the control word at page 0, offset 0x100 reads 0x0000_2000.
- R2: The registers of counter i sit at address i×0x1000. Within a page, offset 0x000 is the event select, 0x004 is the count, 0x008 is the enable (bit 0) and 0x00C is the overflow flag (bit 0). A write to one page leaves every other page unchanged.
- R3: A counter advances by one in a cycle only when three things hold in that cycle: the master enable (control bit 0) is set, the counter's own enable is set, and its event is present.
- R4: Counter 0 advances on every clock in which both enables are set. Its event select reads as 0 and ignores writes.
- R5: An event select keeps only bits 7:0 of the written data. Bits 7:5 name the source port and bits 4:0 name the event code. The selected pulse is bit {port, code} of the event vector.
- R6: For ports 0 to 4, a code is valid only from 0x00 to 0x14. For ports 5 to 7, a code is valid only from 0x00 to 0x11. A counter whose selector is out of range never advances.
- R7: A count wraps from 0xFFFF_FFFF to 0 and sets that counter's overflow flag.
- R8: Writing 1 to bit 0 of an overflow register clears the flag, and writing 0 to it has no effect. If a wrap happens in the same cycle as a clear, the flag stays set.
- R9: Interrupt output i is high exactly while the overflow flag of counter i is set, independently of the other counters.
- R10: When software writes a count in the same cycle as an increment, the written value is kept and the increment is lost.
- R11: Bits 15:11 of the control word read 4, the number of event counters, and writes do not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Byte address: bits 14:12 select the page, bits 11:0 the offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address; 0 when no read is requested |
| evt_pulse | input | 256 | Event pulses, indexed by {port, code} |
| irq_ovf | output | 5 | Per-counter overflow interrupts |

## Verification
The assertions expect reset to be applied before the first access, and `bus_vld` to be used only with addresses that map to a register. They also expect each event pulse to be a clean level for the whole cycle. The bench drives every bus request and every event bit at the falling edge and holds it for exactly one rising edge. Event pulses appear only while no write to the same counter is in flight, except in the two tests built to exercise a collision: write priority and a clear at the moment of a wrap. Interrupt lines and counts are read half a cycle after the edge that updates them.

// File: rtl/icpmu_pkg.sv
package icpmu_pkg;
  localparam int PORT_W = 3;
  localparam int CODE_W = 5;
  localparam int SEL_W = PORT_W + CODE_W;
  localparam int NUM_SRC = 1 << SEL_W;
  localparam int SLV_PORTS = 5;
  localparam logic [CODE_W-1:0] SLV_CODE_MAX = 5'h14;
  localparam logic [CODE_W-1:0] MST_CODE_MAX = 5'h11;

  localparam logic [11:0] OFF_SEL = 12'h000;
  localparam logic [11:0] OFF_VAL = 12'h004;
  localparam logic [11:0] OFF_ENA = 12'h008;
  localparam logic [11:0] OFF_OVF = 12'h00C;
  localparam logic [11:0] OFF_GCTL = 12'h100;

  // A selector is legal when its code lies in the window of its port class.
  function automatic logic sel_in_range(input logic [SEL_W-1:0] sel);
    logic [PORT_W-1:0] port;
    logic [CODE_W-1:0] code;
    port = sel[SEL_W-1:CODE_W];
    code = sel[CODE_W-1:0];
    if (int'(port) < SLV_PORTS) return code <= SLV_CODE_MAX;
    return code <= MST_CODE_MAX;
  endfunction
endpackage

// File: rtl/icpmu_evsel.sv
module icpmu_evsel
  import icpmu_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic               ok,
  output logic               hit
);
  assign ok  = sel_in_range(sel);
  assign hit = ok & evt_pulse[sel];
endmodule

// File: rtl/icpmu_counter.sv
module icpmu_counter
  import icpmu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_sel,
  input  logic               we_val,
  input  logic               we_ena,
  input  logic               we_ovf,
  input  logic [31:0]        wdata,
  input  logic               master_en,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic [CNT_W-1:0]   value,
  output logic [SEL_W-1:0]   sel,
  output logic               ena,
  output logic               ovf,
  output logic               inc,
  output logic               wrap,
  output logic               clr,
  output logic               sel_ok
);
  logic hit;

  generate
    if (IS_CYCLE) begin : g_cyc
      assign sel    = '0;
      assign hit    = 1'b1;
      assign sel_ok = 1'b1;
    end else begin : g_evt
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sel <= '0;
        else if (we_sel) sel <= wdata[SEL_W-1:0];
      icpmu_evsel u_evsel (.sel(sel), .evt_pulse(evt_pulse), .ok(sel_ok), .hit(hit));
    end
  endgenerate

  assign inc  = master_en & ena & hit;
  assign wrap = inc & ~we_val & (&value);
  assign clr  = we_ovf & wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) value <= '0;
    else if (we_val) value <= wdata[CNT_W-1:0];
    else if (inc) value <= value + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ena <= 1'b0;
    else if (we_ena) ena <= wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovf <= 1'b0;
    else if (wrap) ovf <= 1'b1;
    else if (clr) ovf <= 1'b0;
endmodule

// File: rtl/icpmu_top.sv
module icpmu_top
  import icpmu_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_vld,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_SRC-1:0]    evt_pulse,
  output logic [NUM_EVT:0]      irq_ovf
);
  localparam int NUM_CNT = NUM_EVT + 1;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic [PAGE_W-1:0] page;
  logic [11:0]       off;
  logic              wr_go;
  logic              master_en;

  logic [CNT_W-1:0] cnt_val [NUM_CNT];
  logic [SEL_W-1:0] cnt_sel [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_ena, cnt_ovf;
  logic [NUM_CNT-1:0] inc_vec, wrap_vec, clr_vec, sel_ok_vec;

  assign page  = bus_addr[ADDR_W-1:PAGE_LSB];
  assign off   = bus_addr[PAGE_LSB-1:0];
  assign wr_go = bus_vld & bus_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) master_en <= 1'b0;
    else if (wr_go && page == '0 && off == OFF_GCTL) master_en <= bus_wdata[0];

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic pg_hit;
      assign pg_hit = wr_go && (page == PAGE_W'(i));
      icpmu_counter #(.CNT_W(CNT_W), .IS_CYCLE(i == 0)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .we_sel(pg_hit && off == OFF_SEL),
        .we_val(pg_hit && off == OFF_VAL),
        .we_ena(pg_hit && off == OFF_ENA),
        .we_ovf(pg_hit && off == OFF_OVF),
        .wdata(bus_wdata), .master_en(master_en), .evt_pulse(evt_pulse),
        .value(cnt_val[i]), .sel(cnt_sel[i]), .ena(cnt_ena[i]), .ovf(cnt_ovf[i]),
        .inc(inc_vec[i]), .wrap(wrap_vec[i]), .clr(clr_vec[i]), .sel_ok(sel_ok_vec[i])
      );
    end
  endgenerate

  assign irq_ovf = cnt_ovf;

  always_comb begin
    bus_rdata = '0;
    if (bus_vld && !bus_wr) begin
      if (page == '0 && off == OFF_GCTL)
        bus_rdata = {16'b0, 5'(NUM_EVT), 10'b0, master_en};
      for (int i = 0; i < NUM_CNT; i++) begin
        if (page == PAGE_W'(i)) begin
          case (off)
            OFF_SEL: bus_rdata = 32'(cnt_sel[i]);
            OFF_VAL: bus_rdata = 32'(cnt_val[i]);
            OFF_ENA: bus_rdata = 32'(cnt_ena[i]);
            OFF_OVF: bus_rdata = 32'(cnt_ovf[i]);
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/icpmu_chk.sv
module icpmu_chk #(
  parameter int NUM_CNT = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               master_en,
  input logic [NUM_CNT-1:0] inc,
  input logic [NUM_CNT-1:0] wrap,
  input logic [NUM_CNT-1:0] clr,
  input logic [NUM_CNT-1:0] sel_ok,
  input logic [NUM_CNT-1:0] irq
);
  AST_MASTER_GATES: assert property (@(posedge clk) disable iff (!rst_n) !master_en |-> inc == '0); // R3

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_a
      AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n) wrap[i] |=> irq[i]); // R7
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) irq[i] && !clr[i] |=> irq[i]); // R8
      AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) clr[i] && !wrap[i] |=> !irq[i]); // R8
      AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) !irq[i] && !wrap[i] |=> !irq[i]); // R9
      AST_BAD_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sel_ok[i] |-> !inc[i]); // R6
    end
  endgenerate
endmodule

bind icpmu_top icpmu_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .inc(inc_vec),
  .wrap(wrap_vec), .clr(clr_vec), .sel_ok(sel_ok_vec), .irq(irq_ovf)
);

// File: tb/test_icpmu_top.sv
module test_icpmu_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {selector, pulsed bit, expected count after three pulses}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'd3}, {8'h14, 8'h14, 8'd3}, {8'h15, 8'h15, 8'd0},
    {8'h9F, 8'h9F, 8'd0}, {8'hB1, 8'hB1, 8'd3}, {8'hB2, 8'hB2, 8'd0},
    {8'hF0, 8'hF0, 8'd3}, {8'h83, 8'h84, 8'd0}, {8'hE0, 8'hE0, 8'd3}
  };

  logic clk = 0, rst_n = 0, bus_vld = 0, bus_wr = 0;
  logic [14:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [255:0] evt_pulse = '0;
  logic [4:0] irq_ovf;
  int errors = 0, checks = 0;
  bit done = 0;

  icpmu_top i_icpmu_top (.clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq_ovf(irq_ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [14:0] ad(input int pg, input int off);
    return 15'(pg * 4096 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d);
    bus_vld = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_vld = 0; bus_wr = 0;
  endtask

  task automatic rd(input string req, input logic [14:0] a, input logic [31:0] exp);
    bus_vld = 1; bus_wr = 0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    bus_vld = 0;
  endtask

  task automatic pulse(input int bitn, input int n);
    evt_pulse = '0; evt_pulse[bitn] = 1'b1;
    repeat (n) @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int p = 0; p < 5; p++) begin
      rd("R1 count", ad(p, 4), 0);
      rd("R1 flag", ad(p, 12), 0);
      rd("R1 enable", ad(p, 8), 0);
    end
    rd("R1 control", ad(0, 'h100), 32'h2000);
    chk("R1 irq", 32'(irq_ovf), 0);
    // R11 read-only counter-count field
    wr(ad(0, 'h100), 32'hFFFF_FFFF);
    rd("R11 control", ad(0, 'h100), 32'h2001);
    // R5 R6 table of selectors
    for (int k = 0; k < NVEC; k++) begin
      wr(ad(1, 0), 32'(VEC[k][23:16]));
      wr(ad(1, 4), 0);
      wr(ad(1, 8), 1);
      pulse(int'(VEC[k][15:8]), 3);
      rd($sformatf("R6 R5 sel %h", VEC[k][23:16]), ad(1, 4), 32'(VEC[k][7:0]));
    end
    wr(ad(1, 0), 32'h1234_5678);
    rd("R5 select truncation", ad(1, 0), 32'h78);
    // R4 cycle counter
    wr(ad(0, 'h100), 0);
    wr(ad(0, 8), 1);
    wr(ad(0, 4), 0);
    wr(ad(0, 'h100), 1);
    repeat (5) @(negedge clk);
    wr(ad(0, 'h100), 0);
    rd("R4 cycle count", ad(0, 4), 6);
    wr(ad(0, 0), 32'hAB);
    rd("R4 cycle select", ad(0, 0), 0);
    wr(ad(0, 8), 0);
    // R3 enables
    wr(ad(1, 0), 1); wr(ad(1, 4), 0); wr(ad(1, 8), 1);
    pulse(1, 2);
    rd("R3 master off", ad(1, 4), 0);
    wr(ad(0, 'h100), 1); wr(ad(1, 8), 0);
    pulse(1, 2);
    rd("R3 own enable off", ad(1, 4), 0);
    wr(ad(1, 8), 1);
    pulse(1, 2);
    rd("R3 both on", ad(1, 4), 2);
    // R7 R9 wrap
    wr(ad(2, 0), 2); wr(ad(2, 4), 32'hFFFF_FFFE); wr(ad(2, 8), 1);
    pulse(2, 1);
    rd("R7 before wrap", ad(2, 4), 32'hFFFF_FFFF);
    chk("R9 no irq yet", 32'(irq_ovf), 0);
    pulse(2, 1);
    rd("R7 wrapped", ad(2, 4), 0);
    rd("R7 flag", ad(2, 12), 1);
    chk("R9 irq only line 2", 32'(irq_ovf), 32'h4);
    // R8 clear
    wr(ad(2, 12), 0);
    chk("R8 write zero", 32'(irq_ovf[2]), 1);
    wr(ad(2, 12), 1);
    chk("R8 cleared", 32'(irq_ovf[2]), 0);
    wr(ad(2, 4), 32'hFFFF_FFFF);
    evt_pulse = '0; evt_pulse[2] = 1'b1;
    wr(ad(2, 12), 1);
    evt_pulse = '0;
    chk("R8 wrap beats clear", 32'(irq_ovf[2]), 1);
    wr(ad(2, 12), 1);
    // R10 write priority
    wr(ad(3, 0), 3); wr(ad(3, 4), 0); wr(ad(3, 8), 1);
    evt_pulse = '0; evt_pulse[3] = 1'b1;
    wr(ad(3, 4), 32'h100);
    evt_pulse = '0;
    rd("R10 write wins", ad(3, 4), 32'h100);
    pulse(3, 1);
    rd("R10 next increment", ad(3, 4), 32'h101);
    // R2 page separation
    wr(ad(4, 4), 32'hABCD);
    rd("R2 page 4", ad(4, 4), 32'hABCD);
    rd("R2 page 3 intact", ad(3, 4), 32'h101);
    chk("R9 all low", 32'(irq_ovf), 0);
    finish_run();
  end
endmodule